// File: doc/BRIEF.md
# Address and Data Bus Parity Unit

This block protects a processor-side bus with even parity. For each outgoing request it produces two parity bits that cover two uneven slices of a 36-bit address. The three lowest address bits select a byte inside a quadword and are covered by neither bit. For each outgoing write it produces one parity bit per data byte lane.

On reads it recomputes the parity of every returned byte lane and compares it with the parity bits that came back with the data. Only lanes with an active byte enable are compared. A mismatch drives an active-low check output low for the single clock that follows the data-valid clock. Each failing lane is also recorded in a sticky lane register, which holds its bits until a clear input is pulsed. Addresses supplied by other bus masters for snooping are checked against their own two parity bits, and a disagreement is flagged separately for each slice.

All results are registered, so each one appears on the clock after the qualifying valid input.

Top module: `bpar_unit`

## Requirements
- R1: One clock after a cycle with `req_valid` high, `req_ap[0]` equals the XOR of `req_addr[23:3]`, which gives even parity over that slice.
- R2: One clock after a cycle with `req_valid` high, `req_ap[1]` equals the XOR of `req_addr[35:24]`.
- R3: Address bits 2..0 have no effect on `req_ap` or on the snoop check.
- R4: One clock after a cycle with `wr_valid` high, `wr_dp[i]` equals the XOR of `wr_data[8*i+7:8*i]` for every lane i. While `wr_valid` is low, `wr_dp` holds its value.
- R5: `pchk_n` is 0 for exactly the one clock after a cycle in which `rd_valid` is high and some enabled lane i has `rd_dp[i]` different from the XOR of its data byte. In every other clock it is 1.
- R6: A lane whose `rd_be[i]` bit is 0 never causes `pchk_n` to go low and is never recorded in `fail_lanes`.
- R7: One clock after a cycle with `snp_valid` high, `snp_err[k]` is 1 exactly when `snp_ap[k]` differs from the even parity of the slice that `req_ap[k]` covers. Without `snp_valid`, `snp_err` is 0.
- R8: `fail_lanes[i]` is set on the clock after a failing read check on lane i and stays set until `clr_status` is seen high. When a clear and a new failure occur in the same cycle, the clear removes only the old bits and the new failures are recorded.
- R9: While `rst_n` is low, `pchk_n` is 1 and `req_ap`, `wr_dp`, `snp_err` and `fail_lanes` are 0.
- R10: While `req_valid` is low, `req_ap` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Outgoing request address is valid |
| req_addr | input | 36 | Outgoing request address |
| req_ap | output | 2 | Generated address parity bits |
| wr_valid | input | 1 | Outgoing write data is valid |
| wr_data | input | 64 | Outgoing write data |
| wr_dp | output | 8 | Generated parity, one bit per byte lane |
| rd_valid | input | 1 | Returned read data is valid |
| rd_data | input | 64 | Returned read data |
| rd_dp | input | 8 | Returned parity, one bit per byte lane |
| rd_be | input | 8 | Active-high byte enables of the read |
| pchk_n | output | 1 | Read parity error, active low, one clock |
| snp_valid | input | 1 | Snoop address is valid |
| snp_addr | input | 36 | Snoop address from another bus master |
| snp_ap | input | 2 | Parity bits that came with the snoop address |
| snp_err | output | 2 | Snoop parity mismatch, one bit per address slice |
| clr_status | input | 1 | Clears the sticky lane failure record |
| fail_lanes | output | 8 | Sticky record of lanes that failed a read check |

## Verification
The read check and the software clear of the lane record can fall in the same cycle. Directed steps therefore pulse `clr_status` together with a read that has a bad enabled lane, while other lanes already hold old failures. The result is judged by whether only the new lane survives in `fail_lanes` and `pchk_n` still pulses. The snoop check and the read check can also coincide. Random stimulus raises `rd_valid` and `snp_valid` together with corrupted parity on either or both, and the bench compares both outputs against its model every clock.

// File: rtl/bpar_pkg.sv
package bpar_pkg;
    localparam int DEF_ADDR_W = 36;  // width of request and snoop addresses
    localparam int DEF_LANES  = 8;   // number of data byte lanes
    localparam int DEF_LO_BIT = 3;   // lowest address bit covered by parity
    localparam int DEF_SPLIT  = 24;  // first address bit of the upper slice
    localparam int NUM_AP     = 2;   // parity bits per address
endpackage

// File: rtl/bpar_addr_par.sv
module bpar_addr_par #(
    parameter int ADDR_W = bpar_pkg::DEF_ADDR_W,
    parameter int LO_BIT = bpar_pkg::DEF_LO_BIT,
    parameter int SPLIT  = bpar_pkg::DEF_SPLIT
) (
    input  logic [ADDR_W-1:0]           addr,
    output logic [bpar_pkg::NUM_AP-1:0] par
);
    always_comb begin
        par[0] = ^addr[SPLIT-1:LO_BIT];
        par[1] = ^addr[ADDR_W-1:SPLIT];
    end
endmodule

// File: rtl/bpar_lane_par.sv
module bpar_lane_par #(
    parameter int LANES = bpar_pkg::DEF_LANES
) (
    input  logic [LANES*8-1:0] data,
    output logic [LANES-1:0]   par
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign par[i] = ^data[8*i +: 8];
    end
endmodule

// File: rtl/bpar_unit.sv
module bpar_unit #(
    parameter int ADDR_W = bpar_pkg::DEF_ADDR_W,
    parameter int LANES  = bpar_pkg::DEF_LANES,
    parameter int LO_BIT = bpar_pkg::DEF_LO_BIT,
    parameter int SPLIT  = bpar_pkg::DEF_SPLIT
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [ADDR_W-1:0]    req_addr,
    output logic [1:0]           req_ap,
    input  logic                 wr_valid,
    input  logic [LANES*8-1:0]   wr_data,
    output logic [LANES-1:0]     wr_dp,
    input  logic                 rd_valid,
    input  logic [LANES*8-1:0]   rd_data,
    input  logic [LANES-1:0]     rd_dp,
    input  logic [LANES-1:0]     rd_be,
    output logic                 pchk_n,
    input  logic                 snp_valid,
    input  logic [ADDR_W-1:0]    snp_addr,
    input  logic [1:0]           snp_ap,
    output logic [1:0]           snp_err,
    input  logic                 clr_status,
    output logic [LANES-1:0]     fail_lanes
);
    localparam int DATA_W = LANES * 8;

    typedef struct packed {
        logic [1:0]       ap;
        logic [LANES-1:0] dp;
        logic             pchk_n;
        logic [1:0]       snp_err;
        logic [LANES-1:0] fail;
    } state_t;

    state_t st_d, st_q;

    logic [1:0]       req_par;
    logic [1:0]       snp_par;
    logic [LANES-1:0] wr_par;
    logic [LANES-1:0] rd_par;
    logic [LANES-1:0] bad_lanes;

    bpar_addr_par #(.ADDR_W(ADDR_W), .LO_BIT(LO_BIT), .SPLIT(SPLIT)) u_req_par (
        .addr (req_addr),
        .par  (req_par)
    );

    bpar_addr_par #(.ADDR_W(ADDR_W), .LO_BIT(LO_BIT), .SPLIT(SPLIT)) u_snp_par (
        .addr (snp_addr),
        .par  (snp_par)
    );

    bpar_lane_par #(.LANES(LANES)) u_wr_par (
        .data (wr_data[DATA_W-1:0]),
        .par  (wr_par)
    );

    bpar_lane_par #(.LANES(LANES)) u_rd_par (
        .data (rd_data[DATA_W-1:0]),
        .par  (rd_par)
    );

    always_comb begin
        st_d = st_q;
        bad_lanes = rd_valid ? ((rd_par ^ rd_dp) & rd_be) : '0;
        if (req_valid) begin
            st_d.ap = req_par;
        end
        if (wr_valid) begin
            st_d.dp = wr_par;
        end
        st_d.pchk_n  = ~|bad_lanes;
        st_d.snp_err = snp_valid ? (snp_par ^ snp_ap) : 2'b00;
        // clear first, then fresh failures take effect
        st_d.fail    = (clr_status ? '0 : st_q.fail) | bad_lanes;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ap      <= '0;
            st_q.dp      <= '0;
            st_q.pchk_n  <= 1'b1;
            st_q.snp_err <= '0;
            st_q.fail    <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ap     = st_q.ap;
    assign wr_dp      = st_q.dp;
    assign pchk_n     = st_q.pchk_n;
    assign snp_err    = st_q.snp_err;
    assign fail_lanes = st_q.fail;
endmodule

// File: rtl/bpar_unit_chk.sv
module bpar_unit_chk #(
    parameter int LANES = bpar_pkg::DEF_LANES
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [1:0]       req_ap,
    input logic             wr_valid,
    input logic [LANES-1:0] wr_dp,
    input logic             rd_valid,
    input logic [LANES-1:0] rd_be,
    input logic             pchk_n,
    input logic             snp_valid,
    input logic [1:0]       snp_err,
    input logic             clr_status,
    input logic [LANES-1:0] fail_lanes
);
    p_pchk_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !pchk_n |-> $past(rd_valid));

    p_no_be_no_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_be == '0) |=> pchk_n);

    p_snp_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_err != 2'b00) |-> $past(snp_valid));

    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_status |=> ((fail_lanes & $past(fail_lanes)) == $past(fail_lanes)));

    p_err_recorded_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !pchk_n |-> (fail_lanes != '0));

    p_ap_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(req_ap));

    p_dp_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |=> $stable(wr_dp));
endmodule

bind bpar_unit bpar_unit_chk #(.LANES(LANES)) u_chk (.*);

// File: tb/bpar_unit_bench.sv
module bpar_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [35:0] req_addr = '0;
    logic [1:0]  req_ap;
    logic        wr_valid = 1'b0;
    logic [63:0] wr_data = '0;
    logic [7:0]  wr_dp;
    logic        rd_valid = 1'b0;
    logic [63:0] rd_data = '0;
    logic [7:0]  rd_dp = '0;
    logic [7:0]  rd_be = '0;
    logic        pchk_n;
    logic        snp_valid = 1'b0;
    logic [35:0] snp_addr = '0;
    logic [1:0]  snp_ap = '0;
    logic [1:0]  snp_err;
    logic        clr_status = 1'b0;
    logic [7:0]  fail_lanes;

    int errors = 0;
    int checks = 0;

    logic [1:0] exp_ap   = '0;
    logic [7:0] exp_dp   = '0;
    logic       exp_pchk = 1'b1;
    logic [1:0] exp_snp  = '0;
    logic [7:0] exp_fail = '0;

    always #4 clk = ~clk;

    bpar_unit u_bpar_unit (.*);

    function automatic logic [1:0] addr_par(input logic [35:0] a);
        logic [1:0] p;
        p[0] = ^a[23:3];
        p[1] = ^a[35:24];
        return p;
    endfunction

    function automatic logic [7:0] lane_par(input logic [63:0] d);
        logic [7:0] p;
        for (int i = 0; i < 8; i++) p[i] = ^d[8*i +: 8];
        return p;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic rv, input logic [35:0] ra,
                        input logic wv, input logic [63:0] wd,
                        input logic dv, input logic [63:0] dd, input logic [7:0] dp, input logic [7:0] be,
                        input logic sv, input logic [35:0] sa, input logic [1:0] sap,
                        input logic clr);
        logic [7:0] bad;
        req_valid = rv; req_addr = ra;
        wr_valid = wv;  wr_data = wd;
        rd_valid = dv;  rd_data = dd; rd_dp = dp; rd_be = be;
        snp_valid = sv; snp_addr = sa; snp_ap = sap;
        clr_status = clr;
        bad = dv ? ((lane_par(dd) ^ dp) & be) : 8'h00;
        if (rv) exp_ap = addr_par(ra);
        if (wv) exp_dp = lane_par(wd);
        exp_pchk = (bad == 8'h00);
        exp_snp  = sv ? (addr_par(sa) ^ sap) : 2'b00;
        exp_fail = (clr ? 8'h00 : exp_fail) | bad;
        @(posedge clk);
        @(negedge clk);
        check(req_ap[0] == exp_ap[0], "R1 req_ap[0]", 64'(req_ap[0]), 64'(exp_ap[0]));
        check(req_ap[1] == exp_ap[1], "R2 req_ap[1]", 64'(req_ap[1]), 64'(exp_ap[1]));
        check(wr_dp == exp_dp, "R4 wr_dp", 64'(wr_dp), 64'(exp_dp));
        check(pchk_n == exp_pchk, "R5 pchk_n", 64'(pchk_n), 64'(exp_pchk));
        check(snp_err == exp_snp, "R7 snp_err", 64'(snp_err), 64'(exp_snp));
        check(fail_lanes == exp_fail, "R8 fail_lanes", 64'(fail_lanes), 64'(exp_fail));
    endtask

    task automatic idle();
        step(0, '0, 0, '0, 0, '0, '0, '0, 0, '0, '0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [1:0]  ap_keep;
        logic [63:0] dd;
        logic [1:0]  snp_dummy;
        snp_dummy = 2'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        // R9: reset values
        check(pchk_n == 1'b1 && req_ap == 2'b00 && wr_dp == 8'h00 && snp_err == 2'b00 && fail_lanes == 8'h00,
              "R9 reset outputs", 64'({pchk_n, req_ap, wr_dp, snp_err, fail_lanes}), 64'({1'b1, 20'h0}));
        rst_n = 1'b1;
        @(negedge clk);

        // R1, R2: single-bit corners of each slice
        step(1, 36'h8_0000_0008, 0, '0, 0, '0, '0, '0, 0, '0, '0, 0);
        step(1, 36'h0_0100_0000, 0, '0, 0, '0, '0, '0, 0, '0, '0, 0);
        step(1, 36'h0_0080_0000, 0, '0, 0, '0, '0, '0, 0, '0, '0, 0);

        // R3: low bits ignored
        step(1, 36'h1_2345_6780, 0, '0, 0, '0, '0, '0, 0, '0, '0, 0);
        ap_keep = req_ap;
        step(1, 36'h1_2345_6787, 0, '0, 0, '0, '0, '0, 0, '0, '0, 0);
        check(req_ap == ap_keep, "R3 low address bits", 64'(req_ap), 64'(ap_keep));
        step(0, '0, 0, '0, 0, '0, '0, '0, 1, 36'h1_2345_6785, addr_par(36'h1_2345_6780), 0);
        check(snp_err == 2'b00, "R3 snoop low bits", 64'(snp_err), 64'h0);

        // R10: hold without valid
        ap_keep = req_ap;
        step(0, 36'hF_FFFF_FFF8, 0, '0, 0, '0, '0, '0, 0, '0, '0, 0);
        check(req_ap == ap_keep, "R10 hold", 64'(req_ap), 64'(ap_keep));

        // R4: write lanes
        step(0, '0, 1, 64'h0102_0407_F0FF_0080, 0, '0, '0, '0, 0, '0, '0, 0);

        // R6: bad lane 2 with its enable off
        dd = 64'h1122_3344_5566_7788;
        step(0, '0, 0, '0, 1, dd, lane_par(dd) ^ 8'h04, 8'hFB, 0, '0, '0, 0);
        check(pchk_n == 1'b1 && fail_lanes == 8'h00, "R6 disabled lane", 64'({pchk_n, fail_lanes}), 64'h100);

        // R5: one-clock pulse
        step(0, '0, 0, '0, 1, dd, lane_par(dd) ^ 8'h10, 8'hFF, 0, '0, '0, 0);
        check(pchk_n == 1'b0, "R5 pulse low", 64'(pchk_n), 64'h0);
        idle();
        check(pchk_n == 1'b1, "R5 pulse ends", 64'(pchk_n), 64'h1);

        // R8: clear together with new failure on lane 0
        step(0, '0, 0, '0, 1, dd, lane_par(dd) ^ 8'h01, 8'h01, 0, '0, '0, 1);
        check(fail_lanes == 8'h01, "R8 clear with new failure", 64'(fail_lanes), 64'h01);
        step(0, '0, 0, '0, 0, '0, '0, '0, 0, '0, '0, 1);
        check(fail_lanes == 8'h00, "R8 clear", 64'(fail_lanes), 64'h00);

        // R7: snoop and read in the same cycle, both bad
        step(0, '0, 0, '0, 1, dd, lane_par(dd) ^ 8'h80, 8'h80, 1, 36'hA_5A5A_5A58,
             addr_par(36'hA_5A5A_5A58) ^ 2'b11, 0);

        // random mix
        for (int n = 0; n < 2000; n++) begin
            logic [35:0] ra, sa;
            logic [63:0] wd, rdd;
            logic [7:0]  be, dpm;
            logic [1:0]  sm;
            ra  = {4'($urandom), $urandom};
            sa  = {4'($urandom), $urandom};
            wd  = {$urandom, $urandom};
            rdd = {$urandom, $urandom};
            be  = 8'($urandom);
            dpm = ($urandom % 4 == 0) ? 8'($urandom) : 8'h00;
            sm  = ($urandom % 4 == 0) ? 2'($urandom) : 2'b00;
            step(1'($urandom), ra, 1'($urandom), wd,
                 1'($urandom), rdd, lane_par(rdd) ^ dpm, be,
                 1'($urandom), sa, addr_par(sa) ^ sm,
                 ($urandom % 16 == 0));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule